// File: doc/BRIEF.md
# Layered Ring Operand Network

This block moves operands between the function units (FUs) of one compute tile. It uses six unidirectional rings instead of one shared operand bus. The rings form three pairs, and the two rings of a pair run in opposite directions. One pair has a stop at every FU. One pair has stops only at the odd-numbered FUs, and one only at the even-numbered FUs. A hop on the full pair therefore reaches the adjacent FU, and a hop on a sparse pair reaches the FU two positions away. Every stop of every ring holds one operand register, so each ring connection can carry its own operand in the same cycle.

Each FU has three controls. An injection port places a local operand on one selected ring. A receive port reads the operand currently held at the FU's stop on one selected ring. A per-ring forward mask says, for each ring, whether the operand held at this stop moves on at the next edge. An operand that is not forwarded is dropped. A transfer longer than the direct reach is relayed: the schedule forwards the operand through intermediate stops, or it receives the operand at an intermediate FU and injects it again, possibly on another ring.

Top module: `multi_ring_noc`

## Requirements
- R1: While the synchronous active-low reset is applied, and in the first cycle after it, every ring stop is empty. Every `rx_valid` is 0 and every `inj_conflict` is 0.
- R2: An operand that FU i injects on ring r, where FU i has a stop on ring r, is held at FU i's own stop after the next clock edge. FU i sees it with `rx_valid` high when its `rx_ring` selects r, so delivery to itself takes one cycle.
- R3: An operand held at a stop whose `fwd_en` bit for that ring is set occupies the next stop of that ring after the next edge, with unchanged data. An operand injected at stop 0 therefore reaches the stop h hops downstream 1+h cycles after injection.
- R4: Ring codes: 0 = full-up, 1 = full-down, 2 = odd-up, 3 = odd-down, 4 = even-up, 5 = even-down. Codes 6 and 7 select no ring. "Up" goes to increasing FU index and "down" to decreasing index, both modulo NUM_FU. The full rings have a stop at every FU, and one hop moves the operand by one FU index.
- R5: The odd rings have stops at FU indices 1, 3, 5, and so on. The even rings have stops at FU indices 0, 2, 4, and so on. One hop on either sparse pair moves the operand by two FU indices, modulo NUM_FU.
- R6: Two cases have no effect. An injection on a ring where the FU has no stop changes no stop and is seen by no FU. An injection with a no-ring code (6 or 7) likewise changes no stop and is seen by no FU. A receive selecting such a ring or code gives `rx_valid` = 0.
- R7: An operand at a stop whose `fwd_en` bit for that ring is clear is removed at the next edge. It appears neither at that stop nor at the next one, unless a new injection fills them.
- R8: Suppose a stop injects in the same cycle as an operand is forwarded into it from upstream. The forwarded operand wins and the injected operand is discarded. The FU's `inj_conflict` output is high during that cycle.
- R9: All stops of all rings hold and move independent operands in the same cycle.
- R10: A transfer beyond the direct reach completes by relaying. The operand is forwarded along a sparse ring, then received and injected again on another ring, and it arrives with its data intact after one cycle per injection and one cycle per hop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inj_valid | input | NUM_FU | Per-FU injection request |
| inj_ring | input | 3*NUM_FU | Per-FU injection ring code, 3 bits per FU |
| inj_data | input | DW*NUM_FU | Per-FU injected operand, DW bits per FU |
| fwd_en | input | 6*NUM_FU | Per-FU forward mask; bit 6*i+r is for ring r at FU i |
| rx_ring | input | 3*NUM_FU | Per-FU receive ring code |
| rx_valid | output | NUM_FU | Operand present at the selected stop |
| rx_data | output | DW*NUM_FU | Operand at the selected stop |
| inj_conflict | output | NUM_FU | Injection lost to a forwarded operand this cycle |

## Verification
The properties assume that the injection, receive and forward controls are stable around each rising edge. They also assume that ring codes are three-bit values, where codes 6 and 7 only mean "no ring". The hop properties do not take the schedule into account: they follow every valid operand wherever the forward mask sends it.

The bench changes every input half a cycle away from the rising edge. Before each directed scenario it clears the rings by holding the forward mask at zero for one edge, so only the operands it placed there are in flight. The random trials put a single operand on one ring and forward it at every stop. The expected stop after h hops is therefore fixed by the ring's stride and direction alone.

// File: rtl/ring_pkg.sv
// ring_pkg: shared ring numbering and stop-placement helpers.
// Assumes six rings, numbered pair*2 + direction, where direction 0 is "up".
package ring_pkg;

    localparam int NUM_RINGS  = 6;
    localparam int RING_SEL_W = 3;

    typedef enum logic [RING_SEL_W-1:0] {
        RING_FULL_UP   = 3'd0,
        RING_FULL_DN   = 3'd1,
        RING_ODD_UP    = 3'd2,
        RING_ODD_DN    = 3'd3,
        RING_EVEN_UP   = 3'd4,
        RING_EVEN_DN   = 3'd5,
        RING_NONE_A    = 3'd6,
        RING_NONE_B    = 3'd7
    } ring_sel_e;

    // Number of stops on ring r for a tile of n FUs.
    function automatic int lane_stops(input int r, input int n);
        return (r < 2) ? n : n / 2;
    endfunction

    // FU index served by stop j of ring r.
    function automatic int lane_to_fu(input int r, input int j);
        if (r < 2)      return j;
        else if (r < 4) return 2 * j + 1;
        else            return 2 * j;
    endfunction

    // Stop index on ring r for FU i (only meaningful when FU i has a stop there).
    function automatic int fu_to_lane(input int r, input int i);
        return (r < 2) ? i : i / 2;
    endfunction

    // Whether FU i has a stop on ring r.
    function automatic bit has_stop(input int r, input int i);
        if (r < 2)      return 1'b1;
        else if (r < 4) return (i % 2) == 1;
        else if (r < 6) return (i % 2) == 0;
        else            return 1'b0;
    endfunction

    // Mask of rings on which FU i has a stop.
    function automatic logic [NUM_RINGS-1:0] stop_mask(input int i);
        logic [NUM_RINGS-1:0] m;
        for (int r = 0; r < NUM_RINGS; r++) m[r] = has_stop(r, i);
        return m;
    endfunction

    // FU reached by one hop on ring r from FU i in a tile of n FUs.
    function automatic int next_fu(input int r, input int i, input int n);
        int s;
        s = (r < 2) ? 1 : 2;
        return ((r % 2) == 0) ? (i + s) % n : (i + n - s) % n;
    endfunction

endpackage

// File: rtl/ring_lane.sv
// ring_lane: one unidirectional ring of STOPS operand registers.
// Each stop register takes the upstream operand if that stop forwards it,
// otherwise the local injection. A collision is flagged and the forward wins.
// Assumes STOPS >= 1. UP selects whether upstream is the lower stop index.
module ring_lane #(
    parameter int STOPS = 8,
    parameter int DW    = 16,
    parameter bit UP    = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STOPS-1:0]    stop_inj,
    input  logic [STOPS*DW-1:0] stop_inj_data,
    input  logic [STOPS-1:0]    stop_fwd,
    output logic [STOPS-1:0]    slot_v,
    output logic [STOPS*DW-1:0] slot_d,
    output logic [STOPS-1:0]    stop_clash
);

    for (genvar k = 0; k < STOPS; k++) begin : g_stop
        localparam int UPS = UP ? (k + STOPS - 1) % STOPS : (k + 1) % STOPS;

        logic          arrive;
        logic          nxt_v;
        logic [DW-1:0] nxt_d;

        // Pick the operand that occupies this stop after the edge.
        always_comb begin
            arrive        = stop_fwd[UPS] & slot_v[UPS];
            stop_clash[k] = arrive & stop_inj[k];
            if (arrive) begin
                nxt_v = 1'b1;
                nxt_d = slot_d[UPS*DW +: DW];
            end else begin
                nxt_v = stop_inj[k];
                nxt_d = stop_inj_data[k*DW +: DW];
            end
        end

        // Stop register with synchronous active-low reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_v[k]          <= 1'b0;
                slot_d[k*DW +: DW] <= '0;
            end else begin
                slot_v[k]          <= nxt_v;
                slot_d[k*DW +: DW] <= nxt_d;
            end
        end
    end

endmodule

// File: rtl/fu_port.sv
// fu_port: per-FU adapter. Decodes the injection ring code into one
// request per ring, masked to the rings where this FU has a stop, and
// selects the receive operand from this FU's taps.
// Assumes taps are already zero on rings without a stop here.
module fu_port
    import ring_pkg::*;
#(
    parameter int FU_IDX = 0,
    parameter int DW     = 16
) (
    input  logic                    inj_valid,
    input  logic [RING_SEL_W-1:0]   inj_ring,
    input  logic [RING_SEL_W-1:0]   rx_ring,
    input  logic [NUM_RINGS-1:0]    tap_v,
    input  logic [NUM_RINGS*DW-1:0] tap_d,
    output logic [NUM_RINGS-1:0]    inj_req,
    output logic                    rx_valid,
    output logic [DW-1:0]           rx_data
);

    localparam logic [NUM_RINGS-1:0] MASK = stop_mask(FU_IDX);

    // Turn the injection code into a masked one-hot ring request.
    always_comb begin
        inj_req = '0;
        for (int r = 0; r < NUM_RINGS; r++) begin
            if (inj_valid && (32'(inj_ring) == r)) inj_req[r] = MASK[r];
        end
    end

    // Select the operand held at this FU's stop on the receive ring.
    always_comb begin
        rx_valid = 1'b0;
        rx_data  = '0;
        for (int r = 0; r < NUM_RINGS; r++) begin
            if (32'(rx_ring) == r) begin
                rx_valid = tap_v[r];
                rx_data  = tap_d[r*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/multi_ring_noc.sv
// multi_ring_noc: six-ring operand network for one tile of NUM_FU units.
// Builds one lane per ring with the stop count and FU placement of that
// ring, maps the lane stops back to FU positions, and ORs the per-ring
// collision flags into one conflict output per FU.
// Assumes NUM_FU is even and at least 2.
module multi_ring_noc
    import ring_pkg::*;
#(
    parameter int NUM_FU = 8,
    parameter int DW     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_FU-1:0]            inj_valid,
    input  logic [NUM_FU*RING_SEL_W-1:0] inj_ring,
    input  logic [NUM_FU*DW-1:0]         inj_data,
    input  logic [NUM_FU*NUM_RINGS-1:0]  fwd_en,
    input  logic [NUM_FU*RING_SEL_W-1:0] rx_ring,
    output logic [NUM_FU-1:0]            rx_valid,
    output logic [NUM_FU*DW-1:0]         rx_data,
    output logic [NUM_FU-1:0]            inj_conflict
);

    // Ring state seen at FU positions; zero where the FU has no stop.
    logic [NUM_RINGS-1:0][NUM_FU-1:0]          tap_v;
    logic [NUM_RINGS-1:0][NUM_FU-1:0][DW-1:0]  tap_d;
    logic [NUM_RINGS-1:0][NUM_FU-1:0]          clash_map;
    logic [NUM_FU-1:0][NUM_RINGS-1:0]          inj_req;

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        localparam int STOPS = lane_stops(r, NUM_FU);

        logic [STOPS-1:0]    l_inj;
        logic [STOPS-1:0]    l_fwd;
        logic [STOPS-1:0]    l_v;
        logic [STOPS-1:0]    l_clash;
        logic [STOPS*DW-1:0] l_inj_d;
        logic [STOPS*DW-1:0] l_d;

        for (genvar j = 0; j < STOPS; j++) begin : g_in
            localparam int FU = lane_to_fu(r, j);
            assign l_inj[j]            = inj_req[FU][r];
            assign l_fwd[j]            = fwd_en[FU*NUM_RINGS + r];
            assign l_inj_d[j*DW +: DW] = inj_data[FU*DW +: DW];
        end

        ring_lane #(
            .STOPS (STOPS),
            .DW    (DW),
            .UP    ((r % 2) == 0)
        ) u_lane (
            .clk           (clk),
            .rst_n         (rst_n),
            .stop_inj      (l_inj),
            .stop_inj_data (l_inj_d),
            .stop_fwd      (l_fwd),
            .slot_v        (l_v),
            .slot_d        (l_d),
            .stop_clash    (l_clash)
        );

        for (genvar i = 0; i < NUM_FU; i++) begin : g_tap
            if (has_stop(r, i)) begin : g_on
                localparam int J = fu_to_lane(r, i);
                assign tap_v[r][i]     = l_v[J];
                assign tap_d[r][i]     = l_d[J*DW +: DW];
                assign clash_map[r][i] = l_clash[J];
            end else begin : g_off
                assign tap_v[r][i]     = 1'b0;
                assign tap_d[r][i]     = '0;
                assign clash_map[r][i] = 1'b0;
            end
        end
    end

    for (genvar i = 0; i < NUM_FU; i++) begin : g_fu
        logic [NUM_RINGS-1:0]    fu_tap_v;
        logic [NUM_RINGS*DW-1:0] fu_tap_d;

        // Gather this FU's taps across rings.
        always_comb begin
            for (int r = 0; r < NUM_RINGS; r++) begin
                fu_tap_v[r]            = tap_v[r][i];
                fu_tap_d[r*DW +: DW]   = tap_d[r][i];
            end
        end

        // One conflict flag per FU, from any ring at its stops.
        always_comb begin
            inj_conflict[i] = 1'b0;
            for (int r = 0; r < NUM_RINGS; r++) inj_conflict[i] = inj_conflict[i] | clash_map[r][i];
        end

        fu_port #(
            .FU_IDX (i),
            .DW     (DW)
        ) u_port (
            .inj_valid (inj_valid[i]),
            .inj_ring  (inj_ring[i*RING_SEL_W +: RING_SEL_W]),
            .rx_ring   (rx_ring[i*RING_SEL_W +: RING_SEL_W]),
            .tap_v     (fu_tap_v),
            .tap_d     (fu_tap_d),
            .inj_req   (inj_req[i]),
            .rx_valid  (rx_valid[i]),
            .rx_data   (rx_data[i*DW +: DW])
        );
    end

endmodule

// File: rtl/multi_ring_noc_chk.sv
// multi_ring_noc_chk: properties of the ring network, bound to the top.
// Assumes controls are stable around the rising edge.
module multi_ring_noc_chk
    import ring_pkg::*;
#(
    parameter int NUM_FU = 8,
    parameter int DW     = 16
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic [NUM_FU-1:0]                    inj_valid,
    input logic [NUM_FU*RING_SEL_W-1:0]         inj_ring,
    input logic [NUM_FU*DW-1:0]                 inj_data,
    input logic [NUM_FU*NUM_RINGS-1:0]          fwd_en,
    input logic [NUM_FU*RING_SEL_W-1:0]         rx_ring,
    input logic [NUM_FU-1:0]                    rx_valid,
    input logic [NUM_FU-1:0]                    inj_conflict,
    input logic [NUM_RINGS-1:0][NUM_FU-1:0]         tap_v,
    input logic [NUM_RINGS-1:0][NUM_FU-1:0][DW-1:0] tap_d
);

    for (genvar i = 0; i < NUM_FU; i++) begin : g_fu
        AST_CONFLICT_NEEDS_INJECT: assert property (@(posedge clk) disable iff (!rst_n)
            inj_conflict[i] |-> inj_valid[i]); // R8

        AST_NO_RING_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_ring[i*RING_SEL_W +: RING_SEL_W] >= 3'd6) |-> !rx_valid[i]); // R6

        for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
            if (has_stop(r, i)) begin : g_on
                localparam int NXT = next_fu(r, i, NUM_FU);

                AST_INJECT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
                    (inj_valid[i] && (32'(inj_ring[i*RING_SEL_W +: RING_SEL_W]) == r) && !inj_conflict[i])
                    |=> (tap_v[r][i] && (tap_d[r][i] == $past(inj_data[i*DW +: DW])))); // R2

                AST_ONE_HOP: assert property (@(posedge clk) disable iff (!rst_n)
                    (tap_v[r][i] && fwd_en[i*NUM_RINGS + r])
                    |=> (tap_v[r][NXT] && (tap_d[r][NXT] == $past(tap_d[r][i])))); // R3

                AST_DROP_UNFORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
                    (tap_v[r][i] && !fwd_en[i*NUM_RINGS + r] &&
                     !(inj_valid[NXT] && (32'(inj_ring[NXT*RING_SEL_W +: RING_SEL_W]) == r)) &&
                     !(tap_v[r][(r % 2 == 0) ? (i + NUM_FU - ((r < 2) ? 1 : 2)) % NUM_FU
                                             : (i + ((r < 2) ? 1 : 2)) % NUM_FU] &&
                       fwd_en[((r % 2 == 0) ? (i + NUM_FU - ((r < 2) ? 1 : 2)) % NUM_FU
                                            : (i + ((r < 2) ? 1 : 2)) % NUM_FU) * NUM_RINGS + r] &&
                       (NXT == i)))
                    |=> !tap_v[r][NXT]); // R7
            end
        end
    end

endmodule

bind multi_ring_noc multi_ring_noc_chk #(
    .NUM_FU (NUM_FU),
    .DW     (DW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .inj_valid    (inj_valid),
    .inj_ring     (inj_ring),
    .inj_data     (inj_data),
    .fwd_en       (fwd_en),
    .rx_ring      (rx_ring),
    .rx_valid     (rx_valid),
    .inj_conflict (inj_conflict),
    .tap_v        (tap_v),
    .tap_d        (tap_d)
);

// File: tb/test_multi_ring_noc.sv
// Directed bench for multi_ring_noc: one task per scenario.
module test_multi_ring_noc;

    localparam int N  = 8;
    localparam int DW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      inj_valid = '0;
    logic [N*3-1:0]    inj_ring = '0;
    logic [N*DW-1:0]   inj_data = '0;
    logic [N*6-1:0]    fwd_en = '0;
    logic [N*3-1:0]    rx_ring = '0;
    logic [N-1:0]      rx_valid;
    logic [N*DW-1:0]   rx_data;
    logic [N-1:0]      inj_conflict;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    multi_ring_noc #(.NUM_FU(N), .DW(DW)) i_multi_ring_noc (
        .clk (clk), .rst_n (rst_n), .inj_valid (inj_valid), .inj_ring (inj_ring),
        .inj_data (inj_data), .fwd_en (fwd_en), .rx_ring (rx_ring),
        .rx_valid (rx_valid), .rx_data (rx_data), .inj_conflict (inj_conflict)
    );

    function automatic bit stop_at(input int r, input int i);
        if (r < 2) return 1'b1;
        if (r < 4) return (i % 2) == 1;
        if (r < 6) return (i % 2) == 0;
        return 1'b0;
    endfunction

    function automatic int hop_dest(input int r, input int src, input int h);
        int s = (r < 2) ? 1 : 2;
        int d = ((r % 2) == 0) ? s * h : -s * h;
        return (((src + d) % N) + N) % N;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_ctrl();
        inj_valid = '0;
        inj_ring  = '0;
        inj_data  = '0;
        fwd_en    = '0;
    endtask

    task automatic set_inj(input int fu, input int r, input logic [DW-1:0] d);
        inj_valid[fu]           = 1'b1;
        inj_ring[fu*3 +: 3]     = 3'(r);
        inj_data[fu*DW +: DW]   = d;
    endtask

    task automatic set_rx(input int fu, input int r);
        rx_ring[fu*3 +: 3] = 3'(r);
    endtask

    task automatic fwd_ring_all(input int r, input bit v);
        for (int i = 0; i < N; i++) fwd_en[i*6 + r] = v;
    endtask

    // Empty every ring: one edge with no forwarding and no injection.
    task automatic flush();
        clear_ctrl();
        step();
    endtask

    task automatic chk(input string req, input int fu, input bit expv, input logic [DW-1:0] expd);
        #1;
        checks++;
        if (rx_valid[fu] !== expv || (expv && rx_data[fu*DW +: DW] !== expd)) begin
            fails++;
            $display("FAIL %s fu%0d: got v=%0b d=%h, expected v=%0b d=%h",
                     req, fu, rx_valid[fu], rx_data[fu*DW +: DW], expv, expd);
        end
    endtask

    task automatic chk_conflict(input string req, input int fu, input bit exp);
        #1;
        checks++;
        if (inj_conflict[fu] !== exp) begin
            fails++;
            $display("FAIL %s conflict fu%0d: got %0b expected %0b", req, fu, inj_conflict[fu], exp);
        end
    endtask

    // R1: empty after reset on every ring code.
    task automatic t_reset();
        int bad = 0;
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < N; i++) set_rx(i, r);
            #1;
            if (rx_valid !== '0 || inj_conflict !== '0) bad++;
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL R1 reset: got rx_valid=%b conflict=%b expected all 0", rx_valid, inj_conflict);
        end
    endtask

    // R2: self delivery one cycle after injection, on each ring with a stop.
    task automatic t_self();
        flush();
        set_inj(3, 0, 16'h3A30); set_rx(3, 0);
        set_inj(5, 3, 16'h5B53); set_rx(5, 3);
        set_inj(6, 4, 16'h6C64); set_rx(6, 4);
        step();
        clear_ctrl();
        chk("R2 full-up self", 3, 1'b1, 16'h3A30);
        chk("R2 odd-down self", 5, 1'b1, 16'h5B53);
        chk("R2 even-up self", 6, 1'b1, 16'h6C64);
    endtask

    // R3 R4 R5: random source, ring and hop count; arrival at exactly 1+h cycles.
    task automatic t_random_hops();
        for (int t = 0; t < 40; t++) begin
            int src = $urandom % N;
            int r   = $urandom % 6;
            int s, h, dst, early;
            logic [DW-1:0] d = DW'($urandom);
            if (!stop_at(r, src)) src = src ^ 1;
            s   = (r < 2) ? N : N / 2;
            h   = $urandom % s;
            dst = hop_dest(r, src, h);
            flush();
            set_inj(src, r, d);
            fwd_ring_all(r, 1'b1);
            for (int i = 0; i < N; i++) set_rx(i, 7);
            set_rx(dst, r);
            step();
            inj_valid = '0;
            early = 0;
            for (int k = 0; k < h; k++) begin
                #1;
                if (rx_valid[dst]) early++;
                step();
            end
            checks++;
            if (early != 0) begin
                fails++;
                $display("FAIL R3 early arrival ring%0d src%0d dst%0d: got %0d early, expected 0", r, src, dst, early);
            end
            if (r < 2) chk("R4 full ring hop", dst, 1'b1, d);
            else       chk("R5 sparse ring hop", dst, 1'b1, d);
        end
    endtask

    // R6: injection where no stop exists, and no-ring codes, are ignored.
    task automatic t_no_stop();
        int seen = 0;
        flush();
        set_inj(0, 2, 16'hDEAD);
        set_inj(1, 5, 16'hBEEF);
        set_inj(2, 6, 16'hCAFE);
        fwd_ring_all(2, 1'b1); fwd_ring_all(5, 1'b1);
        step();
        inj_valid = '0;
        for (int c = 0; c < 3; c++) begin
            for (int r = 0; r < 8; r++) begin
                for (int i = 0; i < N; i++) set_rx(i, r);
                #1;
                if (rx_valid !== '0) seen++;
            end
            step();
        end
        checks++;
        if (seen != 0) begin
            fails++;
            $display("FAIL R6 ignored injection: got %0d visible samples, expected 0", seen);
        end
        for (int i = 0; i < N; i++) set_rx(i, 7);
        chk("R6 no-ring receive", 4, 1'b0, '0);
    endtask

    // R7: operand not forwarded disappears from its stop and the next.
    task automatic t_drop();
        flush();
        set_inj(3, 0, 16'h7777);
        set_rx(3, 0); set_rx(4, 0);
        step();
        clear_ctrl();
        chk("R7 held one cycle", 3, 1'b1, 16'h7777);
        step();
        chk("R7 removed at stop", 3, 1'b0, '0);
        chk("R7 not passed on", 4, 1'b0, '0);
    endtask

    // R8: forwarded operand beats a same-stop injection.
    task automatic t_conflict();
        flush();
        set_inj(0, 0, 16'hAAAA);
        step();
        clear_ctrl();
        fwd_en[0*6 + 0] = 1'b1;
        set_inj(1, 0, 16'hBBBB);
        set_rx(1, 0);
        chk_conflict("R8", 1, 1'b1);
        chk_conflict("R8 bystander", 2, 1'b0);
        step();
        clear_ctrl();
        chk("R8 forward wins", 1, 1'b1, 16'hAAAA);
    endtask

    // R9: every stop carries its own operand at once.
    task automatic t_concurrent();
        int bad = 0;
        flush();
        for (int i = 0; i < N; i++) begin
            set_inj(i, 0, DW'(16'h1100 + i));
            set_rx(i, 0);
        end
        step();
        clear_ctrl();
        fwd_ring_all(0, 1'b1);
        for (int i = 0; i < N; i++) begin
            #1;
            if (!rx_valid[i] || rx_data[i*DW +: DW] !== DW'(16'h1100 + i)) bad++;
        end
        step();
        for (int i = 0; i < N; i++) begin
            #1;
            if (!rx_valid[i] || rx_data[i*DW +: DW] !== DW'(16'h1100 + (i + N - 1) % N)) bad++;
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL R9 concurrent operands: got %0d mismatches, expected 0", bad);
        end
        clear_ctrl();
    endtask

    // R10: FU0 to FU5 by two even-ring hops, then relay on the full ring.
    task automatic t_relay();
        logic [DW-1:0] got;
        flush();
        set_inj(0, 4, 16'h0F05);
        step();
        clear_ctrl();
        fwd_en[0*6 + 4] = 1'b1;
        step();
        clear_ctrl();
        fwd_en[2*6 + 4] = 1'b1;
        step();
        clear_ctrl();
        set_rx(4, 4);
        chk("R10 relay point", 4, 1'b1, 16'h0F05);
        got = rx_data[4*DW +: DW];
        set_inj(4, 0, got);
        step();
        clear_ctrl();
        fwd_en[4*6 + 0] = 1'b1;
        set_rx(5, 0);
        step();
        clear_ctrl();
        chk("R10 relayed arrival", 5, 1'b1, 16'h0F05);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_self();
        t_random_hops();
        t_no_stop();
        t_drop();
        t_conflict();
        t_concurrent();
        t_relay();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule